// File: doc/BRIEF.md
# Chroma Planar Intra Predictor

This block builds a square block of planar-predicted chroma samples in which the blue-difference (Cb) and red-difference (Cr) components sit interleaved byte by byte. A single start pulse captures four sets of neighbours: the row of pairs above the block, the column of pairs to its left, the pair diagonally above-right and the pair diagonally below-left. The pulse also captures a size code that picks a side length of 4, 8 or 16 pairs. The block then streams the predicted rows, one row per transfer, over a valid/ready handshake.

Each output byte is a weighted blend of four neighbours of its own component. The blend pulls horizontally between the left neighbour of the row and the above-right corner, and vertically between the top neighbour of the column and the below-left corner. The sum is rounded and scaled by a shift of log2(side)+1, which is derived from the leading-zero count of the side length. Every column of the row is computed in parallel, so a row is ready in the same cycle its index is presented. Reference gathering, substitution and smoothing happen upstream of this block.

Top module: `chroma_planar_pred`

## Requirements
- R1: The size code selects the side length nt: 0 gives 4, 1 gives 8, 2 gives 16. A start pulse that carries code 3 is ignored, and the block stays idle with no valid row and no done pulse.
- R2: A start pulse received while idle latches the size code and every reference input. While rows are being emitted, start pulses and reference input changes have no effect on the output.
- R3: For row r and pair column c, each component equals ((nt-1-c)·L[r] + (c+1)·TR + (nt-1-r)·T[c] + (r+1)·BL + nt) >> (log2(nt)+1). In this formula L, T, TR and BL are the samples of that same component.
- R4: The rounding offset is nt and the right shift is log2(nt)+1, so the result always fits in 8 bits for the sizes 4, 8 and 16.
- R5: Within a pair, byte 0 (bits 7:0) is Cb and byte 1 (bits 15:8) is Cr. The column weights apply equally to both bytes, and a Cb result depends on Cb neighbours only.
- R6: Exactly nt rows are emitted per start, in order r = 0 to nt-1, and the row index output shows r for each row. Pair k of the left input belongs to row k, and pair k of the top input belongs to column k.
- R7: The output row places pair c at bytes 2c (Cb) and 2c+1 (Cr), where byte b occupies bits 8b+7:8b. All bytes at positions 2nt and above are zero.
- R8: While a row is valid and not accepted, the valid signal, the row data and the row index hold steady.
- R9: The done output pulses high for exactly one cycle, in the cycle after the last row is accepted. Valid is low in that cycle.
- R10: The first row is valid in the cycle after the start pulse is accepted, and its row index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only while idle |
| size_code_i | input | 2 | Side-length select (0: 4, 1: 8, 2: 16) |
| top_ref_i | input | 256 | Above-row pairs, pair k for column k |
| left_ref_i | input | 256 | Left-column pairs, pair k for row k |
| corner_tr_i | input | 16 | Above-right corner pair |
| corner_bl_i | input | 16 | Below-left corner pair |
| row_valid_o | output | 1 | Row available |
| row_ready_i | input | 1 | Downstream accepts the row |
| row_data_o | output | 256 | Interleaved predicted row, upper bytes zero |
| row_index_o | output | 4 | Index of the row being presented |
| done_o | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
The bench sweeps all three sizes under three ready patterns. It uses references that are all zero, all 255, Cb and Cr set to opposite extremes, and random values. All-255 references reach the largest sum, so a design with an off-by-one shift or a too-narrow accumulator returns wrapped bytes there. Opposite Cb/Cr extremes expose a design that mixes the lanes or applies a column weight to the wrong byte of a pair. The bench also stalls the output with a random ready pattern to catch a row counter that advances without a handshake. It pulses start with new references in the middle of a block to catch a design that re-latches while busy. The bench also looks for a done pulse that arrives a row early or late, and checks that an illegal size code leaves the block idle.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_EMIT = 1'b1
   } cpp_state_e;

   function automatic logic [5:0] lead_zeros32(input logic [31:0] v);
      logic [5:0] n;
      logic       seen;
      n    = 6'd0;
      seen = 1'b0;
      for (int i = 31; i >= 0; i--) begin
         if (v[i]) seen = 1'b1;
         else if (!seen) n = n + 6'd1;
      end
      return n;
   endfunction

   // Scale shift: bit length of the side, equal to log2(side)+1 for powers of two
   function automatic logic [5:0] scale_shift(input logic [31:0] side);
      return 6'd32 - lead_zeros32(side);
   endfunction

endpackage

// File: rtl/cpp_ref_store.sv
module cpp_ref_store #(
   parameter int SAMPLE_W = 8,
   parameter int MAX_LOG2 = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load_i,
   input  logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]   top_i,
   input  logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]   left_i,
   input  logic [2*SAMPLE_W-1:0]               tr_i,
   input  logic [2*SAMPLE_W-1:0]               bl_i,
   output logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]   top_o,
   output logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]   left_o,
   output logic [2*SAMPLE_W-1:0]               tr_o,
   output logic [2*SAMPLE_W-1:0]               bl_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_o  <= '0;
         left_o <= '0;
         tr_o   <= '0;
         bl_o   <= '0;
      end else if (load_i) begin
         top_o  <= top_i;
         left_o <= left_i;
         tr_o   <= tr_i;
         bl_o   <= bl_i;
      end
   end

endmodule

// File: rtl/cpp_row_ctrl.sv
module cpp_row_ctrl #(
   parameter int MIN_LOG2 = 2,
   parameter int MAX_LOG2 = 4
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start_i,
   input  logic [$clog2(MAX_LOG2-MIN_LOG2+2)-1:0]   size_code_i,
   input  logic                                     accept_i,
   output logic                                     load_o,
   output logic                                     busy_o,
   output logic [MAX_LOG2-1:0]                      row_o,
   output logic [MAX_LOG2:0]                        nt_o,
   output logic                                     done_o
);
   import cpp_pkg::*;

   localparam int NUM_SIZES = MAX_LOG2 - MIN_LOG2 + 1;
   localparam int NT_W      = MAX_LOG2 + 1;

   cpp_state_e        state_q;
   logic [NT_W-1:0]   nt_d;
   logic              code_ok;
   logic              last_row;

   assign code_ok  = int'(size_code_i) < NUM_SIZES;
   assign nt_d     = NT_W'(1) << (int'(size_code_i) + MIN_LOG2);
   assign last_row = ({1'b0, row_o} == (nt_o - NT_W'(1)));
   assign load_o   = (state_q == ST_IDLE) && start_i && code_ok;
   assign busy_o   = (state_q == ST_EMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_o   <= '0;
         nt_o    <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (load_o) begin
                  state_q <= ST_EMIT;
                  row_o   <= '0;
                  nt_o    <= nt_d;
               end
            end
            ST_EMIT: begin
               if (accept_i) begin
                  if (last_row) begin
                     state_q <= ST_IDLE;
                     done_o  <= 1'b1;
                  end else begin
                     row_o <= row_o + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: an illegal size code never starts a block
   a_r1_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !code_ok) |=> !busy_o);

   // R2: the latched size holds for the whole block
   a_r2_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(accept_i && last_row)) |=> (busy_o && $stable(nt_o)));

   // R6: rows step by one on each accepted transfer
   a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && accept_i && !last_row) |=> (row_o == $past(row_o) + 1'b1));

   // R9: done follows acceptance of the last row, with the block idle
   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && accept_i && last_row) |=> (done_o && !busy_o));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/cpp_lane.sv
module cpp_lane #(
   parameter int SAMPLE_W = 8,
   parameter int MAX_LOG2 = 4,
   parameter int COL      = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_LOG2:0]    nt_i,
   input  logic [5:0]           shift_i,
   input  logic [MAX_LOG2-1:0]  row_i,
   input  logic [SAMPLE_W-1:0]  top_s,
   input  logic [SAMPLE_W-1:0]  left_s,
   input  logic [SAMPLE_W-1:0]  tr_s,
   input  logic [SAMPLE_W-1:0]  bl_s,
   output logic [SAMPLE_W-1:0]  res_o
);

   localparam int NT_W   = MAX_LOG2 + 1;
   localparam int NEED_W = SAMPLE_W + MAX_LOG2 + 2;
   localparam int ACC_W  = (NEED_W > 16) ? NEED_W : 16;

   logic              active;
   logic [NT_W-1:0]   w_left, w_tr, w_top, w_bl;
   logic [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]  scaled;

   assign active = NT_W'(COL) < nt_i;
   assign w_tr   = NT_W'(COL + 1);
   assign w_left = nt_i - w_tr;
   assign w_bl   = {1'b0, row_i} + NT_W'(1);
   assign w_top  = nt_i - w_bl;

   assign acc = ACC_W'(w_left) * ACC_W'(left_s)
              + ACC_W'(w_tr)   * ACC_W'(tr_s)
              + ACC_W'(w_top)  * ACC_W'(top_s)
              + ACC_W'(w_bl)   * ACC_W'(bl_s)
              + ACC_W'(nt_i);

   assign scaled = acc >> shift_i;
   assign res_o  = active ? scaled[SAMPLE_W-1:0] : '0;

   // R4: the scaled sum never needs more than one sample width
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((scaled >> SAMPLE_W) == '0));

endmodule

// File: rtl/chroma_planar_pred.sv
module chroma_planar_pred #(
   parameter int SAMPLE_W = 8,
   parameter int MIN_LOG2 = 2,
   parameter int MAX_LOG2 = 4
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start_i,
   input  logic [$clog2(MAX_LOG2-MIN_LOG2+2)-1:0]   size_code_i,
   input  logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]        top_ref_i,
   input  logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]        left_ref_i,
   input  logic [2*SAMPLE_W-1:0]                    corner_tr_i,
   input  logic [2*SAMPLE_W-1:0]                    corner_bl_i,
   output logic                                     row_valid_o,
   input  logic                                     row_ready_i,
   output logic [(2*SAMPLE_W<<MAX_LOG2)-1:0]        row_data_o,
   output logic [MAX_LOG2-1:0]                      row_index_o,
   output logic                                     done_o
);
   import cpp_pkg::*;

   localparam int MAX_NT = 1 << MAX_LOG2;
   localparam int PAIR_W = 2 * SAMPLE_W;
   localparam int ROW_W  = PAIR_W * MAX_NT;
   localparam int NT_W   = MAX_LOG2 + 1;

   // Elaboration-time parameter checks
   if (SAMPLE_W < 1 || SAMPLE_W > 16) begin : g_bad_sample
      $error("SAMPLE_W out of range");
   end
   if (MIN_LOG2 < 1) begin : g_bad_min
      $error("MIN_LOG2 must be at least 1");
   end
   if (MAX_LOG2 < MIN_LOG2 || MAX_LOG2 > 6) begin : g_bad_max
      $error("MAX_LOG2 must lie between MIN_LOG2 and 6");
   end

   logic               load_w, busy_w, accept_w;
   logic [NT_W-1:0]    nt_w;
   logic [MAX_LOG2-1:0] row_w;
   logic [5:0]         shift_w;
   logic [ROW_W-1:0]   top_q, left_q;
   logic [PAIR_W-1:0]  tr_q, bl_q, left_sel;

   assign accept_w = busy_w && row_ready_i;

   cpp_row_ctrl #(
      .MIN_LOG2 (MIN_LOG2),
      .MAX_LOG2 (MAX_LOG2)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .size_code_i (size_code_i),
      .accept_i    (accept_w),
      .load_o      (load_w),
      .busy_o      (busy_w),
      .row_o       (row_w),
      .nt_o        (nt_w),
      .done_o      (done_o)
   );

   cpp_ref_store #(
      .SAMPLE_W (SAMPLE_W),
      .MAX_LOG2 (MAX_LOG2)
   ) refs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_w),
      .top_i  (top_ref_i),
      .left_i (left_ref_i),
      .tr_i   (corner_tr_i),
      .bl_i   (corner_bl_i),
      .top_o  (top_q),
      .left_o (left_q),
      .tr_o   (tr_q),
      .bl_o   (bl_q)
   );

   assign shift_w  = scale_shift({{(32-NT_W){1'b0}}, nt_w});
   assign left_sel = left_q[row_w*PAIR_W +: PAIR_W];

   for (genvar c = 0; c < MAX_NT; c++) begin : g_col
      for (genvar k = 0; k < 2; k++) begin : g_comp
         cpp_lane #(
            .SAMPLE_W (SAMPLE_W),
            .MAX_LOG2 (MAX_LOG2),
            .COL      (c)
         ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .nt_i   (nt_w),
            .shift_i(shift_w),
            .row_i  (row_w),
            .top_s  (top_q[(2*c+k)*SAMPLE_W +: SAMPLE_W]),
            .left_s (left_sel[k*SAMPLE_W +: SAMPLE_W]),
            .tr_s   (tr_q[k*SAMPLE_W +: SAMPLE_W]),
            .bl_s   (bl_q[k*SAMPLE_W +: SAMPLE_W]),
            .res_o  (row_data_o[(2*c+k)*SAMPLE_W +: SAMPLE_W])
         );
      end
   end

   assign row_valid_o = busy_w;
   assign row_index_o = row_w;

   // R8: a stalled row keeps its data and index
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid_o && !row_ready_i) |=>
         (row_valid_o && $stable(row_data_o) && $stable(row_index_o)));

   // R10: the first row follows an accepted start
   a_r10_first_row: assert property (@(posedge clk) disable iff (!rst_n)
      load_w |=> (row_valid_o && row_index_o == '0));

   // R2: references hold while rows are emitted
   a_r2_refs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid_o && $past(row_valid_o)) |-> ($stable(top_q) && $stable(left_q)));

endmodule

// File: tb/chroma_planar_pred_tb.sv
`timescale 1ns/1ps
module chroma_planar_pred_tb_top;

   localparam int MAX_NT = 16;
   localparam int ROW_W  = MAX_NT * 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        size_code = 2'd0;
   logic [ROW_W-1:0]  p_top = '0, p_left = '0;
   logic [15:0]       p_tr = '0, p_bl = '0;
   logic [ROW_W-1:0]  m_top, m_left;
   logic [15:0]       m_tr, m_bl;
   logic              ready = 1'b0;
   logic              valid, done;
   logic [ROW_W-1:0]  data;
   logic [3:0]        idx;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2.5 clk = ~clk;

   chroma_planar_pred dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .size_code_i (size_code),
      .top_ref_i   (p_top),
      .left_ref_i  (p_left),
      .corner_tr_i (p_tr),
      .corner_bl_i (p_bl),
      .row_valid_o (valid),
      .row_ready_i (ready),
      .row_data_o  (data),
      .row_index_o (idx),
      .done_o      (done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req,
                      input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [ROW_W-1:0] exp_row(input int nt, input int r);
      logic [ROW_W-1:0] v;
      int sh;
      v  = '0;
      sh = 1;
      for (int n = nt; n > 1; n = n / 2) sh++;
      for (int k = 0; k < 2 * nt; k++) begin
         int c, comp, t, l, tr, bl, s;
         c    = k / 2;
         comp = k % 2;
         t    = int'(m_top[k*8 +: 8]);
         l    = int'(m_left[(2*r+comp)*8 +: 8]);
         tr   = int'(m_tr[comp*8 +: 8]);
         bl   = int'(m_bl[comp*8 +: 8]);
         s    = (nt-1-c)*l + (c+1)*tr + (nt-1-r)*t + (r+1)*bl + nt;
         v[k*8 +: 8] = 8'((s >> sh) & 255);
      end
      return v;
   endfunction

   task automatic fill(input int pat);
      for (int b = 0; b < 2 * MAX_NT; b++) begin
         case (pat)
            0: begin p_top[b*8+:8] = 8'h00; p_left[b*8+:8] = 8'h00; end
            1: begin p_top[b*8+:8] = 8'hFF; p_left[b*8+:8] = 8'hFF; end
            2: begin p_top[b*8+:8] = (b%2 != 0) ? 8'hFF : 8'h00;
                     p_left[b*8+:8] = (b%2 != 0) ? 8'hFF : 8'h00; end
            default: begin p_top[b*8+:8] = 8'($urandom); p_left[b*8+:8] = 8'($urandom); end
         endcase
      end
      case (pat)
         0: begin p_tr = 16'h0000; p_bl = 16'h0000; end
         1: begin p_tr = 16'hFFFF; p_bl = 16'hFFFF; end
         2: begin p_tr = 16'hFF00; p_bl = 16'hFF00; end
         default: begin p_tr = 16'($urandom); p_bl = 16'($urandom); end
      endcase
      m_top = p_top; m_left = p_left; m_tr = p_tr; m_bl = p_bl;
   endtask

   task automatic run_block(input int code, input int rmode, input int pat, input bit disturb);
      int nt, r, cyc;
      bit held_ok;
      logic [ROW_W-1:0] held;
      logic [ROW_W-1:0] e;
      nt = 4 << code;
      fill(pat);
      @(posedge clk); #1;
      size_code = 2'(code);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      r = 0; cyc = 0; held_ok = 0; held = '0;
      while (r < nt && cyc < 2000) begin
         case (rmode)
            0: ready = 1'b1;
            1: ready = (cyc % 2) == 1;
            default: ready = ($urandom % 3) != 0;
         endcase
         if (disturb && cyc == 1) begin
            start = 1'b1;
            size_code = 2'((code + 1) % 3);
            p_top = {8{32'($urandom)}};
            p_left = {8{32'($urandom)}};
            p_tr = 16'($urandom);
            p_bl = 16'($urandom);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         if (cyc == 0) begin
            chk(valid == 1'b1 && idx == 4'd0, "R10 first row valid", ROW_W'({valid, idx}), ROW_W'(5'h10));
            chk(done == 1'b0, "R9 no early done", ROW_W'(done), '0);
         end
         if (held_ok && valid)
            chk(data == held, "R8 stalled row holds", data, held);
         if (valid && ready) begin
            e = exp_row(nt, r);
            chk(data == e, (disturb ? "R2 busy start ignored" : "R3 R4 R5 R7 row value"), data, e);
            chk(idx == 4'(r), "R6 row order", ROW_W'(idx), ROW_W'(r));
            r++;
            held_ok = 0;
         end else if (valid) begin
            held = data;
            held_ok = 1;
         end
         @(posedge clk); #1;
         cyc++;
      end
      start = 1'b0;
      ready = 1'b0;
      if (cyc >= 2000) chk(1'b0, "R6 rows complete", ROW_W'(r), ROW_W'(nt));
      @(negedge clk);
      chk(done == 1'b1 && valid == 1'b0, "R9 done after last row", ROW_W'({done, valid}), ROW_W'(2'b10));
      @(posedge clk); #1;
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", ROW_W'(done), '0);
   endtask

   initial begin
      void'($urandom(32'd77));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(valid == 1'b0 && done == 1'b0, "R7 reset idle", ROW_W'({valid, done}), '0);
      rst_n = 1'b1;

      // R1: illegal size code leaves the block idle
      @(posedge clk); #1;
      fill(3);
      size_code = 2'd3;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(valid == 1'b0 && done == 1'b0, "R1 code 3 ignored", ROW_W'({valid, done}), '0);
      end

      // R1 R3 R4 R5 R6 R7 R8: sweep sizes, ready patterns, reference patterns
      for (int code = 0; code < 3; code++)
         for (int rm = 0; rm < 3; rm++)
            for (int pat = 0; pat < 6; pat++)
               run_block(code, rm, pat, 1'b0);

      // R2: start and new references while busy
      for (int code = 0; code < 3; code++)
         run_block(code, 2, 4, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule